// File: doc/BRIEF.md
# CAS-before-RAS Refresh Sequencer

This block owns the refresh duty of an asynchronous DRAM array built from several devices sharing two row strobes and four column strobes. Once reset is released it keeps every strobe inactive for the start-up pause. It then runs a short burst of warm-up refresh cycles and raises a ready flag. After that it issues one refresh cycle per refresh interval, so that every row is refreshed within the retention period of the selected density variant.

Each refresh is a CAS-before-RAS cycle. The column strobes go low first, the row strobes follow, and the write strobe stays high for the whole cycle. The array's internal row counter picks the row, so no address is driven. The sequencer shares the strobes with an access controller through a request/grant/done handshake. It samples the grant only at the points where a cycle could start. If the grant is withheld, interval ticks are queued up to a fixed depth and then issued back to back once the grant comes.

The block is set up in nanoseconds and clock period. Every cycle count is derived from those parameters. With the defaults (10 ns clock, 2K-row variant) the derived counts are:

| Quantity | Count |
|---|---|
| Start-up pause | 20000 cycles |
| Refresh interval reload | 1554 cycles |
| Precharge | 4 cycles |
| Column set-up | 1 cycle |
| Row-strobe low | 6 cycles |

Top module: `cbr_refresh_seq`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it is raised, all strobes are high (inactive), and `mem_ready`, `ref_req` and `ref_done` are low.
- R2: After reset is released, `ref_req` stays low and all strobes stay high for PAUSE_CYC = ceil(200 us / CLK_NS) clock edges. `ref_req` rises right after the PAUSE_CYC-th edge.
- R3: Exactly 8 refresh cycles (8 `ref_done` pulses) complete before `mem_ready` rises. `mem_ready` is high in the cycle after the 8th `ref_done` pulse and stays high until reset.
- R4: In steady state, with the grant held high, consecutive `ref_done` pulses are RELOAD clock cycles apart. RELOAD = floor(INTERVAL_NS / CLK_NS) - 8. INTERVAL_NS is 32 ms / 2048 for the 2K variant and 64 ms / 4096 for the 4K variant (15625 ns in both cases).
- R5: Before the row strobes fall, all column strobes have been low for at least TCSR_CYC = ceil(5 ns / CLK_NS) cycles. Before that, the row strobes have been high for at least TRP_CYC = ceil(max(40 ns, 5 ns) / CLK_NS) cycles.
- R6: Both row strobes move together and all four column strobes move together. The row strobes stay low for exactly TRAS_CYC = ceil(max(60 ns, 10 ns) / CLK_NS) cycles, and the column strobes stay low for that whole time.
- R7: `we_n` is high at all times.
- R8: A refresh cycle starts only when `ref_grant` is high at a start point. The strobes are all high whenever `ref_req` is low. `ref_done` is a single-cycle pulse in the last cycle of each refresh, after TRP_CYC cycles of recovery.
- R9: Interval ticks that arrive while the grant is withheld are queued, up to 4, and ticks beyond 4 are dropped. Once the grant is given, the queued refreshes run back to back, with `ref_done` pulses TCSR_CYC + TRAS_CYC + TRP_CYC cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_grant | input | 1 | Access controller hands the strobes to the sequencer |
| ref_req | output | 1 | Refresh work is pending or a refresh cycle is in progress |
| ref_done | output | 1 | One-cycle pulse at the end of each refresh cycle |
| mem_ready | output | 1 | Start-up pause and warm-up burst are complete |
| ras_n | output | NUM_RAS | Row strobes, active low |
| cas_n | output | NUM_CAS | Column strobes, active low |
| we_n | output | 1 | Write strobe, held high |

## Verification
The assertions assume that `ref_grant` does not return the strobes to the access controller in the middle of a refresh. Once a cycle has started, the sequencer finishes it without looking at the grant again. The stimulus only changes the grant right after a `ref_done` pulse has been seen, or while no request is outstanding, so every refresh runs to its end under a stable grant. Hold-off windows are aligned to a completed refresh, so the number of ticks queued in each window is known exactly.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,
        PH_WARM  = 2'd1,
        PH_READY = 2'd2
    } init_phase_e;

    typedef enum logic [2:0] {
        CS_IDLE  = 3'd0,
        CS_PRECH = 3'd1,
        CS_CASSU = 3'd2,
        CS_RASLO = 3'd3,
        CS_RECOV = 3'd4
    } cyc_state_e;

    typedef struct packed {
        logic row_act;
        logic col_act;
    } strobe_act_t;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_init_ctl.sv
module rfsh_init_ctl
    import rfsh_pkg::*;
#(
    parameter int PAUSE_CYC   = 20000,
    parameter int WARM_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic done,
    output logic warm_work,
    output logic ready
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int WW = $clog2(WARM_CYCLES + 1);

    init_phase_e   phase_q;
    logic [PW-1:0] pause_q;
    logic [WW-1:0] warm_left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_PAUSE;
            pause_q     <= PW'(PAUSE_CYC - 1);
            warm_left_q <= WW'(WARM_CYCLES);
        end else begin
            unique case (phase_q)
                PH_PAUSE: begin
                    if (pause_q == '0) phase_q <= PH_WARM;
                    else               pause_q <= pause_q - 1'b1;
                end
                PH_WARM: begin
                    if (take && warm_left_q != '0) warm_left_q <= warm_left_q - 1'b1;
                    if (done && warm_left_q == '0) phase_q <= PH_READY;
                end
                default: phase_q <= PH_READY;
            endcase
        end
    end

    assign warm_work = (phase_q == PH_WARM) && (warm_left_q != '0);
    assign ready     = (phase_q == PH_READY);

endmodule

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
    parameter int RELOAD = 1554
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(RELOAD + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= TW'(RELOAD - 1);
        end else if (cnt_q == '0) begin
            cnt_q <= TW'(RELOAD - 1);
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = en && (cnt_q == '0);

endmodule

// File: rtl/rfsh_pend_q.sv
module rfsh_pend_q #(
    parameter int PEND_MAX = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic take,
    output logic has_work
);
    localparam int QW = $clog2(PEND_MAX + 1);

    logic [QW-1:0] cnt_q;
    logic          full;
    logic          empty;

    assign full  = (cnt_q == QW'(PEND_MAX));
    assign empty = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case ({tick, take})
                2'b10:   if (!full)  cnt_q <= cnt_q + 1'b1;
                2'b01:   if (!empty) cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign has_work = !empty;

endmodule

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
    import rfsh_pkg::*;
#(
    parameter int TRP_CYC  = 4,
    parameter int TCSR_CYC = 1,
    parameter int TRAS_CYC = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        work,
    input  logic        grant,
    output logic        take,
    output logic        done,
    output logic        busy,
    output strobe_act_t act
);
    localparam int MAXC = imax(imax(TRP_CYC, TRAS_CYC), TCSR_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    cyc_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          last;

    assign last = (cnt_q == '0);

    always_comb begin
        st_d  = st_q;
        cnt_d = last ? cnt_q : cnt_q - 1'b1;
        take  = 1'b0;
        done  = 1'b0;
        unique case (st_q)
            CS_IDLE: begin
                if (work && grant) begin
                    st_d  = CS_PRECH;
                    cnt_d = CW'(TRP_CYC - 1);
                    take  = 1'b1;
                end
            end
            CS_PRECH: begin
                if (last) begin
                    st_d  = CS_CASSU;
                    cnt_d = CW'(TCSR_CYC - 1);
                end
            end
            CS_CASSU: begin
                if (last) begin
                    st_d  = CS_RASLO;
                    cnt_d = CW'(TRAS_CYC - 1);
                end
            end
            CS_RASLO: begin
                if (last) begin
                    st_d  = CS_RECOV;
                    cnt_d = CW'(TRP_CYC - 1);
                end
            end
            CS_RECOV: begin
                if (last) begin
                    done = 1'b1;
                    if (work && grant) begin
                        st_d  = CS_CASSU;
                        cnt_d = CW'(TCSR_CYC - 1);
                        take  = 1'b1;
                    end else begin
                        st_d = CS_IDLE;
                    end
                end
            end
            default: st_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign busy        = (st_q != CS_IDLE);
    assign act.col_act = (st_q == CS_CASSU) || (st_q == CS_RASLO);
    assign act.row_act = (st_q == CS_RASLO);

endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq
    import rfsh_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter int VARIANT_4K  = 0,
    parameter int PAUSE_NS    = 200000,
    parameter int TRP_NS      = 40,
    parameter int TRPC_NS     = 5,
    parameter int TRAS_NS     = 60,
    parameter int TCSR_NS     = 5,
    parameter int TCHR_NS     = 10,
    parameter int WARM_CYCLES = 8,
    parameter int PEND_MAX    = 4,
    parameter int MARGIN_CYC  = 8,
    parameter int NUM_RAS     = 2,
    parameter int NUM_CAS     = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_grant,
    output logic               ref_req,
    output logic               ref_done,
    output logic               mem_ready,
    output logic [NUM_RAS-1:0] ras_n,
    output logic [NUM_CAS-1:0] cas_n,
    output logic               we_n
);
    localparam int ROWS        = (VARIANT_4K != 0) ? 4096 : 2048;
    localparam int PERIOD_NS   = (VARIANT_4K != 0) ? 64000000 : 32000000;
    localparam int INTERVAL_NS = PERIOD_NS / ROWS;
    localparam int RELOAD      = INTERVAL_NS / CLK_NS - MARGIN_CYC;
    localparam int PAUSE_CYC   = cdiv(PAUSE_NS, CLK_NS);
    localparam int TRP_CYC     = cdiv(imax(TRP_NS, TRPC_NS), CLK_NS);
    localparam int TCSR_CYC    = imax(cdiv(TCSR_NS, CLK_NS), 1);
    localparam int TRAS_CYC    = cdiv(imax(TRAS_NS, TCHR_NS), CLK_NS);

    logic        warm_work;
    logic        pend_work;
    logic        work;
    logic        take;
    logic        take_warm;
    logic        take_pend;
    logic        tick;
    logic        busy;
    logic        done;
    logic        ready;
    strobe_act_t act;

    assign work      = ready ? pend_work : warm_work;
    assign take_warm = take && !ready;
    assign take_pend = take && ready;

    rfsh_init_ctl #(
        .PAUSE_CYC  (PAUSE_CYC),
        .WARM_CYCLES(WARM_CYCLES)
    ) u_init (
        .clk      (clk),
        .rst      (rst),
        .take     (take_warm),
        .done     (done),
        .warm_work(warm_work),
        .ready    (ready)
    );

    rfsh_tick_gen #(
        .RELOAD(RELOAD)
    ) u_tick (
        .clk (clk),
        .rst (rst),
        .en  (ready),
        .tick(tick)
    );

    rfsh_pend_q #(
        .PEND_MAX(PEND_MAX)
    ) u_pend (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .take    (take_pend),
        .has_work(pend_work)
    );

    rfsh_cycle_fsm #(
        .TRP_CYC (TRP_CYC),
        .TCSR_CYC(TCSR_CYC),
        .TRAS_CYC(TRAS_CYC)
    ) u_fsm (
        .clk  (clk),
        .rst  (rst),
        .work (work),
        .grant(ref_grant),
        .take (take),
        .done (done),
        .busy (busy),
        .act  (act)
    );

    genvar gr;
    generate
        for (gr = 0; gr < NUM_RAS; gr++) begin : g_ras
            assign ras_n[gr] = ~act.row_act;
        end
    endgenerate

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CAS; gc++) begin : g_cas
            assign cas_n[gc] = ~act.col_act;
        end
    endgenerate

    assign we_n      = 1'b1;
    assign ref_req   = work || busy;
    assign ref_done  = done;
    assign mem_ready = ready;

endmodule

// File: rtl/cbr_refresh_seq_chk.sv
module cbr_refresh_seq_chk #(
    parameter int NUM_RAS = 2,
    parameter int NUM_CAS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               ref_req,
    input logic               ref_done,
    input logic               mem_ready,
    input logic [NUM_RAS-1:0] ras_n,
    input logic [NUM_CAS-1:0] cas_n,
    input logic               we_n
);
    AST_WE_HIGH: assert property (@(posedge clk) disable iff (rst) we_n == 1'b1); // R7

    AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !ref_req |-> (&ras_n && &cas_n)); // R8

    AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n[0]) |-> ($past(cas_n) == '0)); // R5

    AST_CAS_HELD: assert property (@(posedge clk) disable iff (rst)
        !ras_n[0] |-> (cas_n == '0)); // R6

    AST_STROBES_GANGED: assert property (@(posedge clk) disable iff (rst)
        ($countones(ras_n) == 0 || &ras_n) && ($countones(cas_n) == 0 || &cas_n)); // R6

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        mem_ready |=> mem_ready); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ref_done |=> !ref_done); // R8

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!mem_ready && !ref_req) |-> (&ras_n && &cas_n)); // R2

endmodule

bind cbr_refresh_seq cbr_refresh_seq_chk #(
    .NUM_RAS(NUM_RAS),
    .NUM_CAS(NUM_CAS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_req  (ref_req),
    .ref_done (ref_done),
    .mem_ready(mem_ready),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n)
);

// File: tb/cbr_refresh_seq_test.sv
module cbr_refresh_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int PAUSE_CYC  = 20000;
    localparam int RELOAD     = 15625 / CLK_PERIOD - 8;
    localparam int TRP_CYC    = 4;
    localparam int TCSR_CYC   = 1;
    localparam int TRAS_CYC   = 6;
    localparam int B2B_CYC    = TCSR_CYC + TRAS_CYC + TRP_CYC;
    localparam int NVEC       = 5;
    // each vector: {ticks held off, expected back-to-back refreshes}
    localparam int VEC [NVEC][2] = '{'{1, 1}, '{2, 2}, '{3, 3}, '{5, 4}, '{6, 4}};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_grant = 1'b1;
    logic       ref_req;
    logic       ref_done;
    logic       mem_ready;
    logic [1:0] ras_n;
    logic [3:0] cas_n;
    logic       we_n;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cbr_refresh_seq uut (
        .clk      (clk),
        .rst      (rst),
        .ref_grant(ref_grant),
        .ref_req  (ref_req),
        .ref_done (ref_done),
        .mem_ready(mem_ready),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // strobe-shape monitor
    int ras_hi_run = 0;
    int cas_lo_run = 0;
    int ras_lo_run = 0;
    bit prev_ras   = 1'b1;
    bit cas_bad    = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            ras_hi_run = 0; cas_lo_run = 0; ras_lo_run = 0;
            prev_ras = 1'b1; cas_bad = 1'b0;
        end else begin
            if (prev_ras && !ras_n[0]) begin
                chk(cas_lo_run >= TCSR_CYC, "R5 cas setup", cas_lo_run, TCSR_CYC);
                chk(ras_hi_run >= TRP_CYC, "R5 precharge", ras_hi_run, TRP_CYC);
                chk(we_n == 1'b1, "R7 we_n", we_n, 1);
                chk(ras_n == 2'b00 && cas_n == 4'h0, "R6 ganged", {ras_n, cas_n}, 0);
            end
            if (!ras_n[0] && cas_n != 4'h0) cas_bad = 1'b1;
            if (!prev_ras && ras_n[0]) begin
                chk(ras_lo_run == TRAS_CYC, "R6 ras low width", ras_lo_run, TRAS_CYC);
                chk(!cas_bad, "R6 cas held low", cas_bad, 0);
                cas_bad = 1'b0;
            end
            ras_hi_run = ras_n[0] ? ras_hi_run + 1 : 0;
            ras_lo_run = ras_n[0] ? 0 : ras_lo_run + 1;
            cas_lo_run = (cas_n == 4'h0) ? cas_lo_run + 1 : 0;
            prev_ras   = ras_n[0];
        end
    end

    task automatic wait_done(output int at);
        do @(negedge clk); while (!ref_done);
        at = cyc;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k;
        int dn;
        int c1;
        int c2;
        bit quiet;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(ras_n == 2'b11 && cas_n == 4'hF && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7'h7F);
        chk(!mem_ready && !ref_req && !ref_done, "R1 flags in reset", {mem_ready, ref_req, ref_done}, 0);
        rst = 1'b0;

        // R2 pause length
        k = 0;
        quiet = 1'b1;
        do begin
            @(negedge clk);
            k++;
            if (ras_n != 2'b11 || cas_n != 4'hF || mem_ready) quiet = 1'b0;
        end while (!ref_req && k < PAUSE_CYC + 10);
        chk(k == PAUSE_CYC, "R2 pause cycles", k, PAUSE_CYC);
        chk(quiet, "R2 quiet during pause", quiet, 1);

        // R3 warm-up burst
        dn = 0;
        c1 = 0;
        while (!mem_ready && dn < 20) begin
            @(negedge clk);
            if (ref_done) begin dn++; c1 = cyc; end
        end
        chk(dn == 8, "R3 warm-up count", dn, 8);
        chk(cyc == c1 + 1, "R3 ready after last done", cyc - c1, 1);

        // R4 steady interval
        wait_done(c1);
        wait_done(c2);
        chk(c2 - c1 == RELOAD, "R4 refresh interval", c2 - c1, RELOAD);
        chk(mem_ready, "R3 ready sticky", mem_ready, 1);

        // R9 / R8 hold-off table
        for (int v = 0; v < NVEC; v++) begin
            wait_done(c1);
            ref_grant = 1'b0;
            quiet = 1'b1;
            repeat (VEC[v][0] * RELOAD) begin
                @(negedge clk);
                if (ras_n != 2'b11 || cas_n != 4'hF) quiet = 1'b0;
            end
            chk(quiet, "R8 no strobes without grant", quiet, 1);
            chk(ref_req, "R8 request while held off", ref_req, 1);
            ref_grant = 1'b1;
            dn = 0;
            c1 = 0;
            for (int t = 0; t < 100; t++) begin
                @(negedge clk);
                if (ref_done) begin
                    if (dn > 0) chk(cyc - c1 == B2B_CYC, "R9 back-to-back spacing", cyc - c1, B2B_CYC);
                    dn++;
                    c1 = cyc;
                end
            end
            chk(dn == VEC[v][1], "R9 queued refresh count", dn, VEC[v][1]);
        end

        // R1 reset in the middle of a refresh
        do @(negedge clk); while (ras_n[0]);
        rst = 1'b1;
        @(negedge clk);
        chk(ras_n == 2'b11 && cas_n == 4'hF, "R1 strobes after mid-cycle reset", {ras_n, cas_n}, 6'h3F);
        chk(!mem_ready && !ref_req && !ref_done, "R1 flags after mid-cycle reset", {mem_ready, ref_req, ref_done}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule